// File: doc/BRIEF.md
# Edge Interrupt Pulse Shaper

This block sits between a controller's interrupt event logic and its interrupt output pin. It supports two output behaviours, chosen by a mode input. In edge mode, each event becomes a pulse. The pulse length is programmable in clock cycles. After a pulse, the next one is held back until a programmable number of start-of-frame ticks has passed. Events that arrive while a pulse is running, or while the spacing interval is still counting, are merged into one pending pulse. In level mode, the output simply shows whether an event is pending. The pending state is cleared with a clear input.

Both settings live in one 32-bit configuration word, which is written and read through a plain register port. The spacing field is in the top byte and the pulse-length field is in the low half-word. The byte between them always reads as zero. A spacing of zero turns throttling off. A pulse length of zero is stretched to one clock so that the pulse can still be seen.

Top module: `irq_shaper`

## Requirements
- R1: A write stores bits 31:24 of the write data as the spacing field and bits 15:0 as the pulse-length field. From the next cycle on, the read port returns `{spacing, 8'h00, length}`.
- R2: After synchronous active-high reset, the read port returns 0x0000000F (spacing 0, length 15) and the interrupt output is low.
- R3: Bits 23:16 of the read port are always zero, whatever value was written to them.
- R4: In edge mode, an event that is accepted at a rising edge drives the output high (active-high) from that edge for exactly `length` clock cycles.
- R5: In edge mode, a length of zero gives a pulse of exactly one clock cycle.
- R6: After an edge pulse ends, the spacing counter is loaded with the spacing field and counts down by one on each start-of-frame tick. A new pulse may start only when no pulse is active and the counter is zero. With a spacing of zero, a pending pulse starts on the first clock after the previous pulse ends.
- R7: All events that arrive while a pulse is active or the spacing counter is non-zero collapse into a single pending pulse. That pulse starts on the clock after the counter reaches zero.
- R8: In level mode, the output equals the level-pending flag. An event sets the flag, and the clear input resets it one clock later. An event in the same cycle as a clear wins.
- R9: In level mode, the spacing field and start-of-frame ticks have no effect on the output.
- R10: While level mode is selected, all edge state (pending pulse, pulse counter, spacing counter) is discarded. After a return to edge mode with no new event, the output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Interrupt event strobe, one cycle per event |
| sof_i | input | 1 | Start-of-frame tick strobe |
| level_mode_i | input | 1 | 1 = level output, 0 = edge pulses |
| clr_i | input | 1 | Clears the level-pending flag |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
Every result of this block appears exactly one rising edge after its cause:
- An accepted event raises the output after the edge that samples it.
- A register write appears on the read port after the edge that captures it.
- A clear or a start-of-frame tick changes state at the edge that samples it.

The bench drives all inputs just after the falling edge and advances its behavioural model on the rising edge. It compares both outputs at the next falling edge, so each result is checked in the cycle it becomes due. Directed counts of pulse lengths and pulse starts are taken the same way, at falling edges.

// File: rtl/irq_shaper_pkg.sv
package irq_shaper_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned GAP_W  = 8;
  localparam int unsigned PW_W   = 16;
  localparam int unsigned RSV_W  = REG_W - GAP_W - PW_W;
  localparam logic [PW_W-1:0] PW_RESET = PW_W'(15);

  // a programmed length of zero still yields a one-clock pulse
  function automatic logic [PW_W-1:0] eff_width(input logic [PW_W-1:0] w);
    return (w == '0) ? PW_W'(1) : w;
  endfunction

  // read-back image of the configuration word
  function automatic logic [REG_W-1:0] pack_cfg(input logic [GAP_W-1:0] gap,
                                                input logic [PW_W-1:0]  pw);
    return {gap, {RSV_W{1'b0}}, pw};
  endfunction
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_shaper_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [GAP_W-1:0] gap_o,
  output logic [PW_W-1:0]  pw_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [REG_W-1:0] WMASK = pack_cfg('1, '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_o <= '0;
      pw_o  <= PW_RESET;
    end else if (we) begin
      gap_o <= wdata[REG_W-1 -: GAP_W];
      pw_o  <= wdata[PW_W-1:0];
    end
  end

  assign rdata_o = pack_cfg(gap_o, pw_o);

  // R1 / R3: a write is visible next cycle, reserved bits masked out
  p_write_visible_r1: assert property (@(posedge clk) disable iff (rst)
    we |=> rdata_o == ($past(wdata) & WMASK));
  p_hold_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(rdata_o));
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
  import irq_shaper_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            fire,
  input  logic [PW_W-1:0] pw,
  output logic            active,
  output logic            last
);
  logic [PW_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush)      cnt_q <= '0;
    else if (fire)         cnt_q <= eff_width(pw);
    else if (cnt_q != '0)  cnt_q <= cnt_q - PW_W'(1);
  end

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == PW_W'(1));

  // R5: an accepted fire always produces a visible pulse
  p_fire_visible_r5: assert property (@(posedge clk) disable iff (rst)
    fire && !flush |=> active);
  // R4: a running pulse shortens by exactly one per clock
  p_pulse_step_r4: assert property (@(posedge clk) disable iff (rst)
    active && !flush && !fire |=> cnt_q == $past(cnt_q) - PW_W'(1));
endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer
  import irq_shaper_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             load,
  input  logic             sof,
  input  logic [GAP_W-1:0] gap,
  output logic             idle
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush)           cnt_q <= '0;
    else if (load)              cnt_q <= gap;
    else if (sof && cnt_q != '0) cnt_q <= cnt_q - GAP_W'(1);
  end

  assign idle = (cnt_q == '0);

  // R6: the spacing counter restarts from the field at pulse end
  p_gap_reload_r6: assert property (@(posedge clk) disable iff (rst)
    load && !flush |=> cnt_q == $past(gap));
  // R6: without a tick the counter does not move
  p_gap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sof && !load && !flush |=> $stable(cnt_q));
endmodule

// File: rtl/irq_shaper.sv
module irq_shaper
  import irq_shaper_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             sof_i,
  input  logic             level_mode_i,
  input  logic             clr_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             irq_o
);
  logic [GAP_W-1:0] gap_f;
  logic [PW_W-1:0]  pw_f;
  logic             pulse_active, pulse_last, gap_idle;
  logic             edge_pend_q, lvl_pend_q;
  logic             fire;

  irq_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we_i), .wdata(cfg_wdata_i),
    .gap_o(gap_f), .pw_o(pw_f), .rdata_o(cfg_rdata_o)
  );

  irq_pulse_gen u_pulse (
    .clk(clk), .rst(rst), .flush(level_mode_i), .fire(fire), .pw(pw_f),
    .active(pulse_active), .last(pulse_last)
  );

  irq_gap_timer u_gap (
    .clk(clk), .rst(rst), .flush(level_mode_i), .load(pulse_last),
    .sof(sof_i), .gap(gap_f), .idle(gap_idle)
  );

  // edge path: one merged pending request, released when both timers idle
  assign fire = !level_mode_i && (evt_i || edge_pend_q) && !pulse_active && gap_idle;

  always_ff @(posedge clk) begin
    if (rst || level_mode_i) edge_pend_q <= 1'b0;
    else                     edge_pend_q <= (edge_pend_q || evt_i) && !fire;
  end

  // level path: event wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) lvl_pend_q <= 1'b0;
    else     lvl_pend_q <= evt_i || (lvl_pend_q && !clr_i);
  end

  assign irq_o = level_mode_i ? lvl_pend_q : pulse_active;

  // R6 / R7: a pulse is only released when nothing is running
  p_fire_gated_r6: assert property (@(posedge clk) disable iff (rst)
    fire |-> gap_idle && !pulse_active);
  // R7: a pending request never survives its own release
  p_pend_consumed_r7: assert property (@(posedge clk) disable iff (rst)
    fire && !evt_i |=> !edge_pend_q);
  // R8: clear without event drops the level flag
  p_level_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i && !evt_i |=> !lvl_pend_q);
  p_level_set_r8: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> lvl_pend_q);
  // R10: level mode discards all edge state
  p_flush_edge_r10: assert property (@(posedge clk) disable iff (rst)
    level_mode_i |=> !edge_pend_q && !pulse_active && gap_idle);
endmodule

// File: tb/irq_shaper_tb.sv
module irq_shaper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_i = 0, sof_i = 0, level_mode_i = 0, clr_i = 0, cfg_we_i = 0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  irq_shaper dut_i (
    .clk(clk), .rst(rst), .evt_i(evt_i), .sof_i(sof_i),
    .level_mode_i(level_mode_i), .clr_i(clr_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .irq_o(irq_o)
  );

  // behavioural reference: plain integers, advanced on each rising edge
  int  m_gap, m_pw, m_pulse_left, m_gap_left;
  bit  m_pend, m_lvl;

  always @(posedge clk) begin
    if (rst) begin
      m_gap = 0; m_pw = 15; m_pulse_left = 0; m_gap_left = 0;
      m_pend = 0; m_lvl = 0;
    end else begin
      automatic bit go = !level_mode_i && (evt_i || m_pend)
                         && m_pulse_left == 0 && m_gap_left == 0;
      automatic bit ending = (m_pulse_left == 1);
      m_lvl = evt_i || (m_lvl && !clr_i);
      if (level_mode_i) begin
        m_pend = 0; m_pulse_left = 0; m_gap_left = 0;
      end else begin
        if (ending) m_gap_left = m_gap;
        else if (sof_i && m_gap_left > 0) m_gap_left--;
        if (go) m_pulse_left = (m_pw == 0) ? 1 : m_pw;
        else if (m_pulse_left > 0) m_pulse_left--;
        m_pend = (m_pend || evt_i) && !go;
      end
      if (cfg_we_i) begin
        m_gap = int'(cfg_wdata_i[31:24]);
        m_pw  = int'(cfg_wdata_i[15:0]);
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    return {m_gap[7:0], 8'h00, m_pw[15:0]};
  endfunction

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      automatic logic exp_irq = level_mode_i ? m_lvl : (m_pulse_left != 0);
      checks++;
      if (irq_o !== exp_irq) begin
        errors++;
        $display("FAIL %s irq_o actual=%b expected=%b t=%0t", cur_req, irq_o, exp_irq, $time);
      end
      checks++;
      if (cfg_rdata_o !== exp_rdata()) begin
        errors++;
        $display("FAIL R1 cfg_rdata_o actual=%h expected=%h", cfg_rdata_o, exp_rdata());
      end
    end
  end

  task automatic step(input bit e, input bit s, input bit c);
    evt_i = e; sof_i = s; clr_i = c;
    @(negedge clk); #1;
    evt_i = 0; sof_i = 0; clr_i = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_we_i = 1; cfg_wdata_i = d;
    @(negedge clk); #1;
    cfg_we_i = 0;
  endtask

  task automatic expect_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // counts high cycles and rising edges of irq_o over n idle steps
  task automatic watch(input int n, input int sof_every, output int highs, output int rises);
    bit prev = irq_o;
    highs = 0; rises = 0;
    for (int i = 0; i < n; i++) begin
      step(0, (sof_every > 0) && (i % sof_every == sof_every - 1), 0);
      if (irq_o) highs++;
      if (irq_o && !prev) rises++;
      prev = irq_o;
    end
  endtask

  initial begin
    int h, r;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    // R2: reset values
    expect_int("R2", "rdata after reset", int'(cfg_rdata_o), 32'h0000000F);
    expect_int("R2", "irq after reset", int'(irq_o), 0);

    // R1, R3: field placement and reserved byte
    cur_req = "R1";
    wr(32'hFFFF_FFFF);
    expect_int("R3", "rdata after all-ones", int'(cfg_rdata_o), 32'hFF00FFFF);
    wr(32'h12AB_0004);
    expect_int("R1", "rdata fields", int'(cfg_rdata_o), 32'h12000004);
    wr(32'h00CD_0004);
    expect_int("R3", "reserved byte", int'(cfg_rdata_o[23:16]), 0);

    // R4: pulse of exactly the programmed length
    cur_req = "R4";
    step(1, 0, 0);
    watch(12, 0, h, r);
    expect_int("R4", "pulse length 4", h + 1, 4);
    wr(32'h0000_0007);
    step(1, 0, 0);
    watch(15, 0, h, r);
    expect_int("R4", "pulse length 7", h + 1, 7);

    // R5: zero length gives one clock
    cur_req = "R5";
    wr(32'h0000_0000);
    step(1, 0, 0);
    expect_int("R5", "zero-length pulse high", int'(irq_o), 1);
    watch(6, 0, h, r);
    expect_int("R5", "zero-length pulse total", h + 1, 1);

    // R6: spacing zero, event during pulse -> back-to-back after one idle clock
    cur_req = "R6";
    wr(32'h0000_0003);
    step(1, 0, 0);
    step(1, 0, 0);
    watch(12, 0, h, r);
    expect_int("R6", "second pulse with zero spacing", r, 1);

    // R7: storm of events with spacing 3 and no ticks -> no second pulse
    cur_req = "R7";
    wr(32'h0300_0002);
    step(1, 0, 0);
    for (int i = 0; i < 30; i++) step(1, 0, 0);
    watch(10, 0, h, r);
    expect_int("R7", "pulses while spacing runs", r, 0);
    // three ticks release exactly one merged pulse
    watch(40, 5, h, r);
    expect_int("R7", "merged pulse after spacing", r, 1);

    // R6: mixed traffic with periodic ticks, checked by the model
    cur_req = "R6";
    for (int i = 0; i < 300; i++) step((i % 7) == 0, (i % 4) == 3, 0);
    watch(60, 4, h, r);

    // R8: level mode follows the pending flag
    cur_req = "R8";
    level_mode_i = 1;
    step(0, 0, 1);
    expect_int("R8", "level low after clear", int'(irq_o), 0);
    step(1, 0, 0);
    expect_int("R8", "level high after event", int'(irq_o), 1);
    watch(5, 0, h, r);
    expect_int("R8", "level held", h, 5);
    step(1, 0, 1);
    expect_int("R8", "event wins over clear", int'(irq_o), 1);
    step(0, 0, 1);
    expect_int("R8", "cleared", int'(irq_o), 0);

    // R9: spacing and ticks ignored in level mode
    cur_req = "R9";
    wr(32'hFF00_0001);
    for (int i = 0; i < 20; i++) begin
      step(1, 1, 0);
      expect_int("R9", "level with spacing set", int'(irq_o), 1);
      step(0, 0, 1);
    end

    // R10: leaving level mode leaves no edge residue
    cur_req = "R10";
    level_mode_i = 0;
    wr(32'h0000_0014);
    step(1, 0, 0);
    step(1, 0, 0);
    level_mode_i = 1;
    step(0, 0, 1);
    step(0, 0, 1);
    level_mode_i = 0;
    @(negedge clk); #1;
    watch(40, 3, h, r);
    expect_int("R10", "no edge output after flush", h, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule